// File: doc/BRIEF.md
# Gated Interrupt Request Latches

This block holds two independent interrupt requests for an 8-bit CPU with a Z80-style bus. One request drives an active-low maskable interrupt line, the other an active-low non-maskable interrupt line. The maskable request is set by a rising edge of a vertical timing bit that toggles once per video frame (about 60 Hz). The non-maskable request is set by a falling edge of an external status strobe. Both event inputs are asynchronous, so each passes through a two-stage synchroniser and an edge detector that produces a single-clock set pulse.

Each request has a gate bit that the CPU writes through an I/O port: bit 0 of the data written to port 0xFE gates the maskable request, and bit 0 of the data written to port 0xFF gates the non-maskable one. A gate value of 0 holds the latch cleared, so any event that arrives while the gate is closed is discarded rather than kept for later. A gate value of 1 lets events set the latch. The maskable request is cleared by the CPU's interrupt acknowledge cycle. The non-maskable request clears itself after a fixed number of clocks, so the CPU sees one clean falling edge per strobe.

Top module: `irq_gate_latch`

## Requirements
- R1: While reset is asserted and after it is released, irqN and nmiN are high and both gates are closed, so edges on vertBit or statusStrobeN have no effect until a gate is opened.
- R2: A write cycle (ioWr high at a rising clock edge) to address 0xFE loads ioData bit 0 into the maskable gate; data bits 7..1 are ignored, so writing 0x02 leaves the gate closed.
- R3: A write cycle to address 0xFF loads ioData bit 0 into the non-maskable gate; writing 0 there drives nmiN high from the same clock edge that captures the write.
- R4: With the maskable gate open, a 0-to-1 change of vertBit drives irqN low on the third rising clock edge after the change, and not before.
- R5: With the non-maskable gate open, a 1-to-0 change of statusStrobeN drives nmiN low on the third rising clock edge after the change, and not before.
- R6: Writing 0 to the maskable gate drives irqN high from the clock edge that captures the write; a vertBit rising edge that occurs while the gate is closed is lost and does not set the latch after the gate is reopened.
- R7: An acknowledge cycle (m1N and iorqN both low at a rising clock edge) clears the maskable latch at that edge; if a vertBit rising-edge pulse sets the latch in the same cycle, the set wins. The acknowledge has no effect on nmiN.
- R8: Once set, nmiN stays low for exactly NMI_HOLD clock cycles (default 8) and then returns high; further statusStrobeN falling edges that arrive while nmiN is low are ignored and do not extend or restart the pulse.
- R9: Write cycles to any other address, and address/data values presented with ioWr low, change neither gate.
- R10: A vertBit held high sets the maskable latch only once; after an acknowledge, irqN stays high until the next 0-to-1 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioWr | input | 1 | I/O write strobe, one clock per write cycle |
| ioAddr | input | 8 | I/O port address |
| ioData | input | 8 | I/O write data; only bit 0 is used |
| m1N | input | 1 | CPU opcode-fetch indicator, active low |
| iorqN | input | 1 | CPU I/O request, active low |
| vertBit | input | 1 | Asynchronous frame timing bit; rising edge requests the maskable interrupt |
| statusStrobeN | input | 1 | Asynchronous external status strobe; falling edge requests the non-maskable interrupt |
| irqN | output | 1 | Maskable interrupt request, active low |
| nmiN | output | 1 | Non-maskable interrupt request, active low |

## Verification
The hardest situation to reach is the coincidences: a synchronised edge pulse landing in exactly the same cycle as an acknowledge, or a second strobe fall reaching the latch while the non-maskable pulse is still being held. Directed sequences count clock edges from the input change so the edge pulse meets the acknowledge in the third cycle, and drop the strobe again one cycle after the pulse starts so its event falls inside the hold window. A long random phase then toggles both event inputs, gate writes to the two live addresses and to stray ones, and acknowledge cycles at independent rates, so closed-gate losses and same-cycle collisions recur many times against a cycle-level reference model.

// File: rtl/irq_gate_latch_pkg.sv
package irq_gate_latch_pkg;

  // Strobes from control to datapath, all valid for one clock.
  typedef struct packed {
    logic irqForce;  // maskable gate closed: hold latch clear
    logic irqSet;    // gated vertical rising edge
    logic irqAck;    // interrupt acknowledge cycle
    logic nmiForce;  // non-maskable gate closed: hold latch clear
    logic nmiSet;    // gated strobe falling edge
  } ctrlStrb_t;

  localparam logic [7:0] IRQ_GATE_PORT = 8'hFE;
  localparam logic [7:0] NMI_GATE_PORT = 8'hFF;

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0,
  parameter bit IDLE    = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic edgePulse
);

  // chain[0..STAGES-1] synchronise, chain[STAGES] holds the previous level.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {(STAGES+1){IDLE}};
    else       chain <= {chain[STAGES-1:0], asyncIn};
  end

  generate
    if (FALLING) begin : g_fall
      assign edgePulse = !chain[STAGES-1] && chain[STAGES];
    end else begin : g_rise
      assign edgePulse = chain[STAGES-1] && !chain[STAGES];
    end
  endgenerate

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_latch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              m1N,
  input  logic              iorqN,
  input  logic              vertBit,
  input  logic              statusStrobeN,
  output ctrlStrb_t         strb
);

  logic irqGate, nmiGate;
  logic irqGateEff, nmiGateEff;
  logic wrIrq, wrNmi;
  logic vertRise, strobeFall;
  logic unusedDataBits;

  assign unusedDataBits = ^ioData[DATA_W-1:1];

  irq_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0), .IDLE(1'b0)) u_vertSync (
    .clk(clk), .rstN(rstN), .asyncIn(vertBit), .edgePulse(vertRise)
  );

  irq_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1), .IDLE(1'b1)) u_strobeSync (
    .clk(clk), .rstN(rstN), .asyncIn(statusStrobeN), .edgePulse(strobeFall)
  );

  assign wrIrq = ioWr && (ioAddr == ADDR_W'(IRQ_GATE_PORT));
  assign wrNmi = ioWr && (ioAddr == ADDR_W'(NMI_GATE_PORT));

  // A write takes effect on the latch at the same edge that captures it.
  assign irqGateEff = wrIrq ? ioData[0] : irqGate;
  assign nmiGateEff = wrNmi ? ioData[0] : nmiGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqGate <= 1'b0;
      nmiGate <= 1'b0;
    end else begin
      irqGate <= irqGateEff;
      nmiGate <= nmiGateEff;
    end
  end

  always_comb begin
    strb.irqForce = !irqGateEff;
    strb.irqSet   = vertRise && irqGateEff;
    strb.irqAck   = !m1N && !iorqN;
    strb.nmiForce = !nmiGateEff;
    strb.nmiSet   = strobeFall && nmiGateEff;
  end

endmodule

// File: rtl/irq_gate_datapath.sv
module irq_gate_datapath
  import irq_gate_latch_pkg::*;
#(
  parameter int NMI_HOLD = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  output logic      irqN,
  output logic      nmiN
);

  localparam int CNT_W = (NMI_HOLD > 1) ? $clog2(NMI_HOLD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NMI_HOLD - 1);

  logic             irqLatch, nmiLatch;
  logic [CNT_W-1:0] holdCnt;

  // Priority: closed gate, then set, then acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irqLatch <= 1'b0;
    else if (strb.irqForce) irqLatch <= 1'b0;
    else if (strb.irqSet)   irqLatch <= 1'b1;
    else if (strb.irqAck)   irqLatch <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiLatch <= 1'b0;
      holdCnt  <= '0;
    end else if (strb.nmiForce) begin
      nmiLatch <= 1'b0;
      holdCnt  <= '0;
    end else if (nmiLatch) begin
      if (holdCnt == LAST) begin
        nmiLatch <= 1'b0;
        holdCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end else if (strb.nmiSet) begin
      nmiLatch <= 1'b1;
      holdCnt  <= '0;
    end
  end

  assign irqN = !irqLatch;
  assign nmiN = !nmiLatch;

endmodule

// File: rtl/irq_gate_latch.sv
module irq_gate_latch
  import irq_gate_latch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NMI_HOLD    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              m1N,
  input  logic              iorqN,
  input  logic              vertBit,
  input  logic              statusStrobeN,
  output logic              irqN,
  output logic              nmiN
);

  ctrlStrb_t strb;
  logic      irqSetEv, nmiSetEv;

  assign irqSetEv = strb.irqSet;
  assign nmiSetEv = strb.nmiSet;

  irq_gate_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData),
    .m1N(m1N), .iorqN(iorqN), .vertBit(vertBit), .statusStrobeN(statusStrobeN),
    .strb(strb)
  );

  irq_gate_datapath #(.NMI_HOLD(NMI_HOLD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqN(irqN), .nmiN(nmiN)
  );

endmodule

// File: rtl/irq_gate_latch_chk.sv
module irq_gate_latch_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NMI_HOLD = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWr,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioData,
  input logic              m1N,
  input logic              iorqN,
  input logic              irqN,
  input logic              nmiN,
  input logic              irqSetEv,
  input logic              nmiSetEv
);

  int lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lowCnt <= 0;
    else if (nmiN) lowCnt <= 0;
    else           lowCnt <= lowCnt + 1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (irqN && nmiN));

  assert_irq_from_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(irqSetEv));

  assert_nmi_from_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiN) |-> $past(nmiSetEv));

  assert_irq_gate_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == ADDR_W'(8'hFE) && !ioData[0]) |=> irqN);

  assert_nmi_gate_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == ADDR_W'(8'hFF) && !ioData[0]) |=> nmiN);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && !iorqN && !irqSetEv) |=> irqN);

  assert_nmi_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    !nmiN |-> (lowCnt < NMI_HOLD));

endmodule

bind irq_gate_latch irq_gate_latch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NMI_HOLD(NMI_HOLD)
) u_chk (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData),
  .m1N(m1N), .iorqN(iorqN), .irqN(irqN), .nmiN(nmiN),
  .irqSetEv(irqSetEv), .nmiSetEv(nmiSetEv)
);

// File: tb/sim_irq_gate_latch.sv
`timescale 1ns/1ps
module sim_irq_gate_latch;

  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rstN;
  logic       ioWr = 1'b0;
  logic [7:0] ioAddr = 8'h00;
  logic [7:0] ioData = 8'h00;
  logic       m1N = 1'b1;
  logic       iorqN = 1'b1;
  logic       vertBit = 1'b0;
  logic       statusStrobeN = 1'b1;
  logic       irqN, nmiN;

  int  nChecks = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  bit  modelOn = 1'b0;

  always #2 clk = ~clk;

  irq_gate_latch #(.NMI_HOLD(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData),
    .m1N(m1N), .iorqN(iorqN), .vertBit(vertBit), .statusStrobeN(statusStrobeN),
    .irqN(irqN), .nmiN(nmiN)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements: 2 sync stages, edge, latch.
  logic mS1V, mS2V, mPV, mS1S, mS2S, mPS, mGI, mGN, mIrq, mNmi;
  int   mCnt;

  function automatic logic gateNext(input logic cur, input logic [7:0] port);
    return (ioWr && ioAddr == port) ? ioData[0] : cur;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1V = 0; mS2V = 0; mPV = 0; mS1S = 1; mS2S = 1; mPS = 1;
      mGI = 0; mGN = 0; mIrq = 0; mNmi = 0; mCnt = 0;
    end else begin
      logic rise, fall, eI, eN, ack;
      rise = mS2V && !mPV;
      fall = !mS2S && mPS;
      eI   = gateNext(mGI, 8'hFE);
      eN   = gateNext(mGN, 8'hFF);
      ack  = !m1N && !iorqN;
      if (!eI) mIrq = 0;
      else if (rise) mIrq = 1;
      else if (ack) mIrq = 0;
      if (!eN) begin mNmi = 0; mCnt = 0; end
      else if (mNmi) begin
        if (mCnt == HOLD - 1) begin mNmi = 0; mCnt = 0; end
        else mCnt++;
      end else if (fall) begin mNmi = 1; mCnt = 0; end
      mGI = eI; mGN = eN;
      mPV = mS2V; mS2V = mS1V; mS1V = vertBit;
      mPS = mS2S; mS2S = mS1S; mS1S = statusStrobeN;
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN && !done) begin
      chk(irqN, !mIrq, "R7 irq model");
      chk(nmiN, !mNmi, "R8 nmi model");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    ioWr = 1'b1; ioAddr = a; ioData = d;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic ackCycle();
    m1N = 1'b0; iorqN = 1'b0;
    @(negedge clk);
    m1N = 1'b1; iorqN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd5150));
    rstN = 1'b1;
    #1 rstN = 1'b0;
    tick(3);
    chk(irqN, 1'b1, "R1 irqN in reset");
    chk(nmiN, 1'b1, "R1 nmiN in reset");
    rstN = 1'b1;
    modelOn = 1'b1;
    tick(1);
    chk(irqN, 1'b1, "R1 irqN after reset");
    // R1: events with gates closed
    vertBit = 1; statusStrobeN = 0; tick(5);
    chk(irqN, 1'b1, "R1 vert edge ignored");
    chk(nmiN, 1'b1, "R1 strobe edge ignored");
    vertBit = 0; statusStrobeN = 1; tick(4);
    // R2: upper data bits ignored
    ioWrite(8'hFE, 8'h02);
    vertBit = 1; tick(4);
    chk(irqN, 1'b1, "R2 bit1 does not open gate");
    vertBit = 0; tick(4);
    // R4: latency
    ioWrite(8'hFE, 8'h01);
    vertBit = 1; tick(2);
    chk(irqN, 1'b1, "R4 not before third edge");
    tick(1);
    chk(irqN, 1'b0, "R4 set on third edge");
    // R10: held level sets once
    ackCycle();
    chk(irqN, 1'b1, "R7 ack clears");
    tick(5);
    chk(irqN, 1'b1, "R10 held level no re-set");
    // R7: set beats ack in same cycle
    vertBit = 0; tick(4);
    vertBit = 1; tick(2);
    m1N = 0; iorqN = 0; tick(1); m1N = 1; iorqN = 1;
    chk(irqN, 1'b0, "R7 set wins over ack");
    ackCycle();
    chk(irqN, 1'b1, "R7 later ack clears");
    // R6: close gate, lost event
    vertBit = 0; tick(4); vertBit = 1; tick(4);
    chk(irqN, 1'b0, "R6 setup");
    ioWrite(8'hFE, 8'h00);
    chk(irqN, 1'b1, "R6 clear at write edge");
    vertBit = 0; tick(4); vertBit = 1; tick(4);
    ioWrite(8'hFE, 8'h01);
    tick(3);
    chk(irqN, 1'b1, "R6 event while closed is lost");
    // R9: stray writes, idle bus
    ioWrite(8'hFD, 8'hFF);
    ioAddr = 8'hFF; ioData = 8'h01; tick(1);
    statusStrobeN = 0; tick(4);
    chk(nmiN, 1'b1, "R9 nmi gate unchanged");
    statusStrobeN = 1; tick(4);
    // R5 / R8
    ioWrite(8'hFF, 8'h01);
    statusStrobeN = 0; tick(2);
    chk(nmiN, 1'b1, "R5 not before third edge");
    tick(1);
    chk(nmiN, 1'b0, "R5 set on third edge");
    statusStrobeN = 1; tick(1); statusStrobeN = 0;
    tick(HOLD - 2);
    chk(nmiN, 1'b0, "R8 still low at last hold cycle");
    tick(1);
    chk(nmiN, 1'b1, "R8 released after hold");
    tick(4);
    chk(nmiN, 1'b1, "R8 edge during hold ignored");
    // R3: closing gate clears nmi
    statusStrobeN = 1; tick(4); statusStrobeN = 0; tick(3);
    chk(nmiN, 1'b0, "R3 setup");
    ioWrite(8'hFF, 8'h00);
    chk(nmiN, 1'b1, "R3 clear at write edge");
    statusStrobeN = 1; tick(2);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(5) == 0) vertBit = ~vertBit;
      if ($urandom_range(4) == 0) statusStrobeN = ~statusStrobeN;
      if ($urandom_range(9) == 0) begin
        int sel = $urandom_range(3);
        ioWr = 1'b1;
        ioAddr = (sel == 0) ? 8'hFE : (sel == 1) ? 8'hFF : (sel == 2) ? 8'hFD : 8'($urandom);
        ioData = 8'($urandom);
      end else begin
        ioWr = 1'b0;
      end
      if ($urandom_range(11) == 0) begin m1N = 0; iorqN = 0; end
      else begin m1N = $urandom_range(1); iorqN = 1; end
      tick(1);
    end
    ioWr = 0; m1N = 1; iorqN = 1;
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule